// File: doc/BRIEF.md
# Parallel ADC Read Sequencer

This block runs on a fast system clock and controls a successive-approximation converter that has a parallel data bus. It pulls the convert line low at a rate the host programs. It then waits for the converter's busy flag to fall. Next it runs one chip-select/read access, latches the parallel word and offers it to the host on a valid/ready pair. A new conversion does not begin until the host has taken the previous word.

Every analogue timing minimum is a parameter counted in system-clock cycles:
- convert-low width
- busy blanking window
- read-low width and data access time
- bus release time
- acquisition time
- wake-up time

In power-down mode the convert line stays low through the whole conversion, so the converter powers itself down. The line is raised as busy drops, which wakes the converter, and the next conversion waits out the wake-up delay. A busy flag that never drops is reported as a one-cycle error strobe.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and after it is released, `cnv_start_n`, `adc_cs_n` and `adc_rd_n` are 1, and `res_valid` and `conv_err` are 0.
- R2: With `shutdown_mode` = 0 at the start of a conversion, `cnv_start_n` stays low for exactly T_START_LO cycles.
- R3: Busy is passed through SYNC_STAGES flops. It is ignored until T_BUSY_BLANK+SYNC_STAGES cycles after `cnv_start_n` falls. `adc_cs_n` and `adc_rd_n` fall together on the (SYNC_STAGES+1)-th rising edge after `adc_busy` falls, and never while `adc_busy` is high.
- R4: `adc_rd_n` stays low for exactly max(T_RD_LO, T_ACCESS) cycles. `adc_cs_n` is low whenever `adc_rd_n` is low and rises on the same edge as `adc_rd_n`.
- R5: The word on `adc_data` in the last read-low cycle is captured. `res_valid` rises T_RELQ cycles after `adc_rd_n` rises, carrying that word on `res_data`.
- R6: `cnv_start_n` never falls sooner than T_ACQ cycles after `adc_busy` falls.
- R7: With `shutdown_mode` = 1, `cnv_start_n` stays low until busy is seen low and rises on the same edge that `adc_rd_n` falls. The next falling edge comes no sooner than T_WAKE cycles after that rise.
- R8: Successive falling edges of `cnv_start_n` are at least `sample_period` cycles apart. When the period is the only limit, they are exactly `sample_period`+1 cycles apart.
- R9: `res_valid` and `res_data` hold until `res_ready` is seen. No conversion starts while `res_valid` is 1.
- R10: If busy has not dropped T_TIMEOUT cycles after `cnv_start_n` fell, `conv_err` pulses for one cycle, T_TIMEOUT+1 cycles after that fall. `cnv_start_n` is 1 from that pulse on, and no result is produced.
- R11: While `en` is 0, no conversion is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows new conversions |
| shutdown_mode | input | 1 | 1 = power-down conversion shape, latched per conversion |
| sample_period | input | CNT_W | Minimum cycles between convert falling edges |
| res_ready | input | 1 | Host accepts the offered word |
| res_valid | output | 1 | Captured word is offered |
| res_data | output | DW | Captured conversion word |
| conv_err | output | 1 | One-cycle busy-timeout strobe |
| cnv_start_n | output | 1 | Convert-start line to the converter, active low |
| adc_busy | input | 1 | Converter busy flag, asynchronous |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_data | input | DW | Converter parallel data bus |

## Verification
Each result has a fixed delay from its cause:
- The read strobe follows the busy fall by SYNC_STAGES+1 edges.
- The read strobe's low width is max(T_RD_LO, T_ACCESS).
- The valid strobe comes T_RELQ cycles after the read strobe rises.
- The timeout strobe comes T_TIMEOUT+1 cycles after the convert fall.
- With a dominant period, convert falls are `sample_period`+1 cycles apart.

The bench samples on falling clock edges and timestamps every output edge with a cycle counter, so each delay is compared as an exact difference. The converter model drives busy on falling edges, so its busy fall is seen one sample late, and the bench allows for this.

The minimum-gap rules (acquisition, wake-up) are checked as lower bounds. The converter model drives a poison word until the access time has elapsed, so an early capture shows up as a data mismatch.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_CONV,
        S_READ,
        S_RELQ
    } seq_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_elapsed.sv
module adc_rd_elapsed #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)                 count_d = '0;
        else if (count_q != '1)  count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '1;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DW           = 12,
    parameter int CNT_W        = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int T_START_LO   = 3,
    parameter int T_BUSY_BLANK = 2,
    parameter int T_RD_LO      = 6,
    parameter int T_ACCESS     = 5,
    parameter int T_RELQ       = 1,
    parameter int T_ACQ        = 20,
    parameter int T_WAKE       = 200,
    parameter int T_TIMEOUT    = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             shutdown_mode,
    input  logic [CNT_W-1:0] sample_period,
    input  logic             res_ready,
    output logic             res_valid,
    output logic [DW-1:0]    res_data,
    output logic             conv_err,
    output logic             cnv_start_n,
    input  logic             adc_busy,
    output logic             adc_cs_n,
    output logic             adc_rd_n,
    input  logic [DW-1:0]    adc_data
);
    localparam int RD_LEN = (T_RD_LO > T_ACCESS) ? T_RD_LO : T_ACCESS;
    localparam int WAKE_LIM = (T_WAKE > T_ACQ) ? T_WAKE : T_ACQ;
    localparam logic [CNT_W-1:0] BLANK_C   = CNT_W'(T_BUSY_BLANK + SYNC_STAGES);
    localparam logic [CNT_W-1:0] TOUT_C    = CNT_W'(T_TIMEOUT);
    localparam logic [CNT_W-1:0] ACQ_C     = CNT_W'(T_ACQ);
    localparam logic [CNT_W-1:0] WAKE_C    = CNT_W'(WAKE_LIM);
    localparam logic [CNT_W-1:0] START_C   = CNT_W'(T_START_LO - 1);
    localparam logic [CNT_W-1:0] RD_C      = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] RELQ_C    = CNT_W'(T_RELQ - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             start_n;
        logic             cs_n;
        logic             rd_n;
        logic             valid;
        logic             err;
        logic             mode;
        logic [CNT_W-1:0] tmr;
        logic [DW-1:0]    data;
    } seq_regs_t;

    seq_regs_t        seq_d, seq_q;
    logic             busy_s;
    logic             clr_start, clr_acq;
    logic [CNT_W-1:0] since_start, since_acq, acq_lim;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_busy),
        .dout  (busy_s)
    );

    adc_rd_elapsed #(.W(CNT_W)) u_since_start (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_start),
        .count (since_start)
    );

    adc_rd_elapsed #(.W(CNT_W)) u_since_acq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_acq),
        .count (since_acq)
    );

    // the previous conversion's shape decides the quiet time before the next
    assign acq_lim = seq_q.mode ? WAKE_C : ACQ_C;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        clr_start = 1'b0;
        clr_acq   = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (seq_q.valid && res_ready) seq_d.valid = 1'b0;
                if (en && !seq_q.valid && (since_start >= sample_period)
                        && (since_acq >= acq_lim)) begin
                    seq_d.st      = S_START;
                    seq_d.start_n = 1'b0;
                    seq_d.tmr     = START_C;
                    seq_d.mode    = shutdown_mode;
                    clr_start     = 1'b1;
                end
            end
            S_START: begin
                if (seq_q.tmr == '0) begin
                    seq_d.start_n = ~seq_q.mode;
                    seq_d.st      = S_CONV;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            S_CONV: begin
                if ((since_start >= BLANK_C) && !busy_s) begin
                    seq_d.start_n = 1'b1;
                    seq_d.cs_n    = 1'b0;
                    seq_d.rd_n    = 1'b0;
                    seq_d.tmr     = RD_C;
                    seq_d.st      = S_READ;
                    clr_acq       = 1'b1;
                end else if (since_start >= TOUT_C) begin
                    seq_d.start_n = 1'b1;
                    seq_d.err     = 1'b1;
                    seq_d.st      = S_IDLE;
                    clr_acq       = 1'b1;
                end
            end
            S_READ: begin
                if (seq_q.tmr == '0) begin
                    seq_d.data = adc_data;
                    seq_d.cs_n = 1'b1;
                    seq_d.rd_n = 1'b1;
                    seq_d.tmr  = RELQ_C;
                    seq_d.st   = S_RELQ;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            S_RELQ: begin
                if (seq_q.tmr == '0) begin
                    seq_d.valid = 1'b1;
                    seq_d.st    = S_IDLE;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q         <= '0;
            seq_q.st      <= S_IDLE;
            seq_q.start_n <= 1'b1;
            seq_q.cs_n    <= 1'b1;
            seq_q.rd_n    <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cnv_start_n = seq_q.start_n;
    assign adc_cs_n    = seq_q.cs_n;
    assign adc_rd_n    = seq_q.rd_n;
    assign res_valid   = seq_q.valid;
    assign res_data    = seq_q.data;
    assign conv_err    = seq_q.err;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
    parameter int DW         = 12,
    parameter int T_START_LO = 3,
    parameter int T_RD_LO    = 6,
    parameter int T_ACCESS   = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnv_start_n,
    input logic          adc_busy,
    input logic          adc_cs_n,
    input logic          adc_rd_n,
    input logic          res_valid,
    input logic          res_ready,
    input logic [DW-1:0] res_data,
    input logic          conv_err
);
    localparam int RD_LEN = (T_RD_LO > T_ACCESS) ? T_RD_LO : T_ACCESS;

    int unsigned lo_cnt, rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= 0;
            rd_cnt <= 0;
        end else begin
            lo_cnt <= cnv_start_n ? 0 : ((lo_cnt < 32'hFFFF) ? lo_cnt + 1 : lo_cnt);
            rd_cnt <= adc_rd_n ? 0 : ((rd_cnt < 32'hFFFF) ? rd_cnt + 1 : rd_cnt);
        end
    end

    AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_start_n) |-> lo_cnt >= T_START_LO);                          // R2
    AST_RD_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rd_n) |-> !adc_busy);                                          // R3
    AST_CS_COVERS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_cs_n);                                                // R4
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |-> rd_cnt == RD_LEN);                                   // R4
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data));             // R9
    AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !$fell(cnv_start_n));                                      // R9
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_err |=> !conv_err);                                                 // R10
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .DW         (DW),
    .T_START_LO (T_START_LO),
    .T_RD_LO    (T_RD_LO),
    .T_ACCESS   (T_ACCESS)
) u_adc_rd_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnv_start_n (cnv_start_n),
    .adc_busy    (adc_busy),
    .adc_cs_n    (adc_cs_n),
    .adc_rd_n    (adc_rd_n),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .conv_err    (conv_err)
);

// File: tb/test_adc_rd_ctrl.sv
`timescale 1ns/1ps
module test_adc_rd_ctrl;
    localparam int DW = 12, CNT_W = 16, SYNC = 2;
    localparam int T_START_LO = 3, T_BUSY_BLANK = 2, T_RD_LO = 6, T_ACCESS = 5;
    localparam int T_RELQ = 1, T_ACQ = 20, T_WAKE = 40, T_TIMEOUT = 60;
    localparam int RD_LEN = (T_RD_LO > T_ACCESS) ? T_RD_LO : T_ACCESS;
    localparam int CONV_CYC = 14;
    localparam logic [DW-1:0] POISON = 12'hA5A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, shutdown_mode = 1'b0, res_ready = 1'b1;
    logic [CNT_W-1:0] sample_period = '0;
    logic res_valid, conv_err, cnv_start_n, adc_cs_n, adc_rd_n;
    logic [DW-1:0] res_data, adc_data;
    logic busy_m = 1'b0;

    always #2.5 clk = ~clk;

    adc_rd_ctrl #(
        .DW(DW), .CNT_W(CNT_W), .SYNC_STAGES(SYNC), .T_START_LO(T_START_LO),
        .T_BUSY_BLANK(T_BUSY_BLANK), .T_RD_LO(T_RD_LO), .T_ACCESS(T_ACCESS),
        .T_RELQ(T_RELQ), .T_ACQ(T_ACQ), .T_WAKE(T_WAKE), .T_TIMEOUT(T_TIMEOUT)
    ) i_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .shutdown_mode(shutdown_mode),
        .sample_period(sample_period), .res_ready(res_ready), .res_valid(res_valid),
        .res_data(res_data), .conv_err(conv_err), .cnv_start_n(cnv_start_n),
        .adc_busy(busy_m), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_data(adc_data)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int k);
        return DW'(k * 419 + 7);
    endfunction

    // converter model: busy on falling clock edges, word presented after access time
    logic ms_prev = 1'b1;
    int conv_left = 0, word_k = 0, rdlo = 0;
    logic [DW-1:0] word_reg = '0;
    bit stuck = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            busy_m <= 1'b0; conv_left <= 0; word_k <= 0; rdlo <= 0; ms_prev <= 1'b1;
        end else begin
            if (ms_prev && !cnv_start_n) begin
                busy_m <= 1'b1; conv_left <= CONV_CYC;
            end else if (busy_m && !stuck) begin
                if (conv_left == 1) begin
                    busy_m <= 1'b0; word_reg <= word_of(word_k); word_k <= word_k + 1;
                end
                conv_left <= conv_left - 1;
            end
            rdlo    <= (!adc_cs_n && !adc_rd_n) ? rdlo + 1 : 0;
            ms_prev <= cnv_start_n;
        end
    end
    assign adc_data = (rdlo >= T_ACCESS) ? word_reg : POISON;

    // monitor: timestamps in falling-edge samples
    int cyc = 0, n_res = 0, n_falls = 0;
    int t_fall = 0, t_rise = 0, t_bfall = -1000, t_rdf = 0, t_rdr = 0;
    bit have_prev = 0, cur_mode = 0, prev_mode = 0;
    logic sp = 1, bp = 0, rp = 1, vp = 0, ep = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sp && !cnv_start_n) begin
                n_falls++;
                if (have_prev) begin
                    chk(cyc - t_fall >= int'(sample_period), "R8", cyc - t_fall, int'(sample_period));
                    if (sample_period >= 200)
                        chk(cyc - t_fall == int'(sample_period) + 1, "R8", cyc - t_fall, int'(sample_period) + 1);
                    if (prev_mode)
                        chk(cyc - t_rise >= T_WAKE, "R7", cyc - t_rise, T_WAKE);
                end
                chk(cyc - t_bfall >= T_ACQ, "R6", cyc - t_bfall, T_ACQ);
                chk(en, "R11", 0, 1);
                prev_mode = cur_mode; cur_mode = shutdown_mode;
                t_fall = cyc; have_prev = 1;
            end
            if (!sp && cnv_start_n) begin
                t_rise = cyc;
                if (!cur_mode) chk(cyc - t_fall == T_START_LO, "R2", cyc - t_fall, T_START_LO);
                else chk(!adc_rd_n || conv_err, "R7", int'(adc_rd_n), 0);
            end
            if (bp && !busy_m) begin
                t_bfall = cyc;
                chk(cnv_start_n == !cur_mode, "R7", int'(cnv_start_n), int'(!cur_mode));
            end
            if (rp && !adc_rd_n) begin
                t_rdf = cyc;
                chk(cyc - t_bfall == SYNC, "R3", cyc - t_bfall, SYNC);
                chk(!adc_cs_n, "R4", int'(adc_cs_n), 0);
            end
            if (!rp && adc_rd_n) begin
                t_rdr = cyc;
                chk(cyc - t_rdf == RD_LEN, "R4", cyc - t_rdf, RD_LEN);
                chk(adc_cs_n, "R4", int'(adc_cs_n), 1);
            end
            if (!vp && res_valid) begin
                chk(cyc - t_rdr == T_RELQ, "R5", cyc - t_rdr, T_RELQ);
                chk(res_data == word_of(n_res), "R5", int'(res_data), int'(word_of(n_res)));
                n_res++;
            end
            if (!ep && conv_err) begin
                chk(cyc - t_fall == T_TIMEOUT + 1, "R10", cyc - t_fall, T_TIMEOUT + 1);
                chk(cnv_start_n, "R10", int'(cnv_start_n), 1);
            end
            sp = cnv_start_n; bp = busy_m; rp = adc_rd_n; vp = res_valid; ep = conv_err;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_cfg(input bit mode, input int period, input int nconv);
        int target;
        en = 1'b0;
        repeat (60) @(negedge clk);
        shutdown_mode = mode; sample_period = CNT_W'(period); have_prev = 0;
        target = n_res + nconv;
        en = 1'b1;
        while (n_res < target) @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cnv_start_n && adc_cs_n && adc_rd_n, "R1", 0, 1);
        chk(!res_valid && !conv_err, "R1", int'(res_valid), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(cnv_start_n && adc_cs_n && adc_rd_n && !res_valid, "R1", 0, 1);
        chk(n_falls == 0, "R11", n_falls, 0);

        for (int m = 0; m < 2; m++) begin
            run_cfg(m[0], 0, 3);
            run_cfg(m[0], 25, 3);
            run_cfg(m[0], 300, 3);
        end

        begin : hold_test
            int falls0;
            logic [DW-1:0] held;
            en = 1'b0;
            repeat (60) @(negedge clk);
            shutdown_mode = 1'b0; sample_period = '0; have_prev = 0;
            res_ready = 1'b0; en = 1'b1;
            while (!res_valid) @(negedge clk);
            held = res_data; falls0 = n_falls;
            repeat (80) @(negedge clk);
            chk(res_valid, "R9", int'(res_valid), 1);
            chk(res_data == held, "R9", int'(res_data), int'(held));
            chk(n_falls == falls0, "R9", n_falls - falls0, 0);
            res_ready = 1'b1;
            @(negedge clk);
            chk(!res_valid, "R9", int'(res_valid), 0);
            en = 1'b0;
            repeat (60) @(negedge clk);
        end

        begin : timeout_test
            int res0;
            shutdown_mode = 1'b1; stuck = 1; have_prev = 0; res0 = n_res;
            en = 1'b1;
            while (!conv_err) @(negedge clk);
            en = 1'b0;
            repeat (30) @(negedge clk);
            chk(n_res == res0 && !res_valid, "R10", n_res - res0, 0);
            chk(cnv_start_n, "R10", int'(cnv_start_n), 1);
        end

        finish_run();
    end

    initial begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "watchdog", 1, 0);
        finish_run();
    end
endmodule